// File: doc/BRIEF.md
# Battery Charge Estimator with Level Classifier

This block keeps a running figure for the charge left in a battery and refreshes it once per accepted reaction. On a cycle where `in_valid` is high it takes two unsigned fixed-point samples: a raw charge reading from the sensor, and the charge believed to have been drawn since the previous update. It first deducts the drawn charge from the held estimate, clamping at zero. It then decides whether the raw reading is trustworthy. A reading that lies closer to the held estimate than a configurable bound is blended in with a configurable weight. A reading outside that bound is dropped, and the estimate simply follows the deduction.

A second register sorts the estimate into three bands, low, medium and high, using two threshold inputs. The blend weight, the trust bound and both thresholds are plain configuration inputs that may change on any cycle. The block needs no divider and no floating point: the weight is a fraction with 8 fraction bits, and the blend is two full-width products followed by a right shift. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `charge_tracker`

## Requirements
- R1: While reset is active, and until the synchronized release has passed, `est_q` equals the parameter INIT_CHARGE and `level_q` reads 2'b00.
- R2: On a clock edge where `in_valid` is low, `est_q` keeps its value.
- R3: On an update, the deducted value is `est_q - spent`, or zero when `spent` exceeds `est_q`.
- R4: When |`est_q` - `meas`| < `trust_bound`, the new estimate is (deducted*(256-a) + meas*a) >> 8, truncated, where a is the `blend_wt` value.
- R5: When |`est_q` - `meas`| >= `trust_bound` (equality included), the new estimate is the deducted value and `meas` has no effect on it.
- R6: `blend_wt` is an unsigned fraction with 8 fraction bits (256 = 1.0). A value above 256 acts as 256. With a weight of 256 an accepted reading replaces the estimate. With a weight of 0 the result is the deducted value.
- R7: `level_q` encodes the class as 2'b00 for low when est <= `thr_low`, 2'b01 for medium when `thr_low` < est <= `thr_high`, and 2'b10 for high otherwise. The code 2'b11 never appears.
- R8: `level_q` is registered. After each clock edge it shows the class of the `est_q` value held before that edge, judged against the thresholds present at that edge, so it lags an estimate change by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Update strobe for this cycle |
| meas | input | CW | Raw charge reading |
| spent | input | CW | Charge consumed since the last update |
| blend_wt | input | FB+1 | Blend weight, fraction with FB fraction bits |
| trust_bound | input | CW | Exclusive bound on the reading's distance from the estimate |
| thr_low | input | CW | Upper limit of the low band |
| thr_high | input | CW | Upper limit of the medium band |
| est_q | output | CW | Registered charge estimate |
| level_q | output | 2 | Registered charge class |

## Verification
The bench targets a distance exactly equal to the trust bound. A design using <= there would blend a reading it should drop. It drives consumption larger than the estimate, which a design without the zero clamp would wrap to a large value that reads as a full battery. It uses weights of 0, 256 and above 256, where a design without saturation would let an over-range weight overflow the complement term. It also moves the estimate across a threshold and checks that the class lags by exactly one cycle; a combinational or doubly registered class would show up as a mismatch on that cycle.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;
endpackage

// File: rtl/chg_step.sv
module chg_step #(
  parameter int CW = 16,
  parameter int FB = 8
) (
  input  logic [CW-1:0] cur,
  input  logic [CW-1:0] meas,
  input  logic [CW-1:0] spent,
  input  logic [CW-1:0] bound,
  input  logic [FB:0]   wt,
  output logic [CW-1:0] nxt,
  output logic          accept
);
  localparam int PW = CW + FB + 1;
  localparam logic [FB:0] ONE = (FB+1)'(1) << FB;

  logic [CW-1:0] drop, gap, blended;
  logic [FB:0]   w_eff, w_keep;
  logic [PW-1:0] prod_d, prod_m;
  logic [PW:0]   acc;

  always_comb begin
    drop    = (spent > cur) ? '0 : cur - spent;
    gap     = (cur >= meas) ? cur - meas : meas - cur;
    accept  = gap < bound;
    w_eff   = (wt > ONE) ? ONE : wt;
    w_keep  = ONE - w_eff;
    prod_d  = PW'(drop) * PW'(w_keep);
    prod_m  = PW'(meas) * PW'(w_eff);
    acc     = {1'b0, prod_d} + {1'b0, prod_m};
    blended = acc[FB +: CW];
    nxt     = accept ? blended : drop;
  end

  // the weighted mean must stay between its two operands
  always_comb begin
    if (accept) begin
      assert_blend_bounded_R4: assert ((blended >= drop || blended >= meas) &&
                                       (blended <= drop || blended <= meas));
    end
  end
endmodule

// File: rtl/chg_classify.sv
module chg_classify #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] value,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output chg_pkg::lvl_e lvl
);
  always_comb begin
    if (value <= lo)      lvl = chg_pkg::LVL_LOW;
    else if (value <= hi) lvl = chg_pkg::LVL_MID;
    else                  lvl = chg_pkg::LVL_HIGH;
  end
endmodule

// File: rtl/charge_tracker.sv
module charge_tracker #(
  parameter int          CW          = 16,
  parameter int          FB          = 8,
  parameter logic [CW-1:0] INIT_CHARGE = 16'd40000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] meas,
  input  logic [CW-1:0] spent,
  input  logic [FB:0]   blend_wt,
  input  logic [CW-1:0] trust_bound,
  input  logic [CW-1:0] thr_low,
  input  logic [CW-1:0] thr_high,
  output logic [CW-1:0] est_q,
  output logic [1:0]    level_q
);
  import chg_pkg::*;

  logic [1:0]    sync_q;
  logic          rst_ok;
  logic [CW-1:0] step_nxt, est_d;
  logic          step_acc;
  lvl_e          lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_ok = sync_q[1];

  chg_step #(.CW(CW), .FB(FB)) u_step (
    .cur(est_q), .meas(meas), .spent(spent), .bound(trust_bound),
    .wt(blend_wt), .nxt(step_nxt), .accept(step_acc)
  );

  chg_classify #(.CW(CW)) u_cls (
    .value(est_q), .lo(thr_low), .hi(thr_high), .lvl(lvl_d)
  );

  always_comb begin
    est_d = est_q;
    if (in_valid) est_d = step_nxt;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      est_q   <= INIT_CHARGE;
      level_q <= LVL_LOW;
    end else begin
      if (in_valid) est_q <= est_d;
      level_q <= lvl_d;
    end
  end

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> $stable(est_q));

  assert_reject_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !step_acc) |=> est_q <= $past(est_q));

  assert_level_code_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    level_q != 2'b11);

  assert_level_low_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (est_q <= thr_low) |=> level_q == 2'b00);

  assert_level_high_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (est_q > thr_low && est_q > thr_high) |=> level_q == 2'b10);
endmodule

// File: tb/charge_tracker_bench.sv
module charge_tracker_bench;
  localparam int CW = 16;
  localparam int FB = 8;
  localparam int INIT = 40000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, in_valid;
  logic [CW-1:0] meas, spent, trust_bound, thr_low, thr_high, est_q;
  logic [FB:0]   blend_wt;
  logic [1:0]    level_q;

  int total = 0;
  int bad = 0;
  int m_est;

  charge_tracker #(.CW(CW), .FB(FB), .INIT_CHARGE(16'(INIT))) u_charge_tracker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .meas(meas), .spent(spent),
    .blend_wt(blend_wt), .trust_bound(trust_bound), .thr_low(thr_low),
    .thr_high(thr_high), .est_q(est_q), .level_q(level_q)
  );

  function automatic int cls(int v, int lo, int hi);
    if (v <= lo) return 0;
    if (v <= hi) return 1;
    return 2;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called just after a negedge: drive one cycle, predict, compare at next negedge
  task automatic step(bit v, int m, int s);
    int d, gap, a, ne, nl;
    string tag;
    in_valid = v; meas = 16'(m); spent = 16'(s);
    nl = cls(m_est, int'(thr_low), int'(thr_high));
    ne = m_est;
    tag = "R2 idle hold";
    if (v) begin
      d   = (s > m_est) ? 0 : m_est - s;
      gap = (m_est >= m) ? m_est - m : m - m_est;
      if (gap < int'(trust_bound)) begin
        a  = (int'(blend_wt) > 256) ? 256 : int'(blend_wt);
        ne = (d * (256 - a) + m * a) >> 8;
        tag = "R4 R6 blend";
      end else begin
        ne = d;
        tag = "R3 R5 reject";
      end
    end
    @(negedge clk);
    chk(tag, int'(est_q), ne);
    chk("R7 R8 level", int'(level_q), nl);
    m_est = ne;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; meas = '0; spent = '0;
    blend_wt = 9'd64; trust_bound = 16'd500; thr_low = 16'd20000; thr_high = 16'd45000;
    repeat (3) @(negedge clk);
    chk("R1 reset est", int'(est_q), INIT);
    chk("R1 reset level", int'(level_q), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sync release est", int'(est_q), INIT);
    chk("R1 sync release level", int'(level_q), 0);
    repeat (3) @(negedge clk);
    m_est = INIT;
    chk("R7 level after release", int'(level_q), 1);

    // R4 blend with a plain weight
    step(1, INIT + 100, 20);
    // R5: distance equal to bound is rejected
    step(1, m_est + 500, 10);
    step(1, m_est - 500, 10);
    // R6 saturating and zero weights
    blend_wt = 9'd256; step(1, m_est + 300, 5);
    blend_wt = 9'd400; step(1, m_est - 300, 5);
    blend_wt = 9'd0;   step(1, m_est + 200, 7);
    // R2 idle with a wild reading
    step(0, 0, 9000);
    // R3 clamp at zero: consumption above estimate, reading far away
    step(1, 65535, 60000);
    chk("R3 clamp to zero", int'(est_q), 0);
    // R8 lag: lift estimate from low to high, level follows one cycle later
    blend_wt = 9'd256; trust_bound = 16'hFFFF;
    step(1, 50000, 0);
    chk("R8 level still old class", int'(level_q), 0);
    step(0, 0, 0);
    chk("R8 level now high", int'(level_q), 2);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int off, m, s;
      if (i % 200 == 0) begin
        blend_wt = 9'd256; trust_bound = 16'hFFFF;
        step(1, $urandom_range(0, 65535), 0);
        blend_wt = 9'($urandom_range(0, 300));
        trust_bound = 16'($urandom_range(1, 800));
        thr_low = 16'($urandom_range(5000, 30000));
        thr_high = 16'($urandom_range(25000, 60000));
      end
      off = $urandom_range(0, 1200) - 600;
      m = m_est + off;
      if ($urandom_range(0, 9) == 0) m = $urandom_range(0, 65535);
      if (m < 0) m = 0;
      if (m > 65535) m = 65535;
      s = ($urandom_range(0, 49) == 0) ? $urandom_range(0, 65535) : $urandom_range(0, 60);
      step($urandom_range(0, 3) != 0, m, s);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule